// File: doc/BRIEF.md
# Effective Address Mode Decoder

This unit resolves the memory operand address of a byte-coded instruction. A controller pulses `start` with the first opcode byte and the address of the byte that follows it. The decoder classifies the opcode's addressing field and pulls any extension bytes it needs from the instruction stream through a request/acknowledge byte port. It reads base and index registers from a 32-bit register file through one combinational read port. When it is finished it reports the effective address, the number of extra cycles the chosen mode costs, and, for one form, a register code instead of an address.

The supported forms are register-indirect, register with a signed 8-bit offset, and absolute addresses of 8, 16 or 24 bits. An extended form is selected by a mode byte and gives register plus signed register, register plus signed 16-bit offset, bare register, or PC-relative with a 16-bit offset. Two auto-modify forms step a register by 1, 2 or 4 before or after use, and write the new register value back through a write port. Opcodes that carry no memory operand complete at once with nothing fetched.

Results stay on the outputs from the `done` pulse until the next operation writes them. The unit does not execute the instruction.

Top module: `eam_decoder`

## Requirements
- R1: During and directly after synchronous reset, `done`, `fetch_req`, `rf_we` and `rcode_valid` are low and `ea` is zero.
- R2: Opcodes 0x80–0xBF with bit 3 clear give `ea` equal to register GPR_BASE+opcode[2:0] (GPR_BASE defaults to 56), with 0 extra cycles and no bytes fetched.
- R3: Opcodes 0x80–0xBF with bit 3 set fetch one byte, sign-extend it and add it to that register, costing 2 extra cycles.
- R4: Opcodes 0xC0–0xFF with low nibble 0, 1 or 2 fetch 1, 2 or 3 bytes forming a zero-extended absolute address, first byte least significant, costing 2, 2 and 3 extra cycles.
- R5: Low nibble 3 fetches a mode byte. Mode 0x03 or 0x07 fetches a base code and an index code. The base register is the base code's bits 7:2. The index is the index register's byte at lane code[1:0] (0x03) or its halfword chosen by code[1] (0x07), sign-extended and added. Cost is 8.
- R6: Mode byte 0x13 fetches two more bytes as a signed 16-bit offset (low byte first) and gives `pc_base`+3+offset, wrapping modulo 2^32, at cost 8.
- R7: Any other mode byte costs 5 and names the register in its bits 7:2. If its bits 1:0 are 01, a signed 16-bit offset follows and is added; otherwise the register itself is the address and only the mode byte is fetched.
- R8: Low nibble 4 (pre-decrement) fetches one byte: register in bits 7:2, step code in bits 1:0 (0→1, 1→2, 2→4). The register minus the step is both the address and the value written back. Cost is 3.
- R9: Low nibble 5 (post-increment) uses the same byte layout. The address is the old register value and the register plus the step is written back. Cost is 3.
- R10: Step code 3 in either auto-modify form leaves the register unchanged, and the address is the register value.
- R11: Low nibble 7, except opcode 0xF7, fetches one byte, presents it on `rcode` with `rcode_valid` high, gives `ea` zero and costs 1.
- R12: Opcodes below 0x80, opcode 0xF7, and 0xC0–0xFF opcodes with low nibble 6 or 8–F fetch nothing. They give `ea` zero, 0 cycles and no register code, with `done` two clock edges after the start edge.
- R13: A byte is taken only on a clock edge where `fetch_req` and `fetch_ack` are both high. `fetch_req` stays high until acknowledged. Exactly the bytes the mode needs are taken, and stalls do not change any result.
- R14: `start` is ignored while an operation is in progress, and `done` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding `opcode` (taken only when idle) |
| opcode | input | 8 | First opcode byte |
| pc_base | input | 32 | Address of the first byte after the opcode |
| fetch_req | output | 1 | Requests the next instruction-stream byte |
| fetch_ack | input | 1 | Byte on `fetch_byte` is valid this cycle |
| fetch_byte | input | 8 | Instruction-stream byte |
| rf_rd_idx | output | 6 | Register file read index |
| rf_rd_data | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register writeback strobe for auto-modify forms |
| rf_wr_idx | output | 6 | Writeback register index |
| rf_wr_data | output | 32 | Writeback value |
| ea | output | 32 | Effective address |
| extra_cyc | output | 4 | Extra cycle count of the decoded mode |
| rcode_valid | output | 1 | `rcode` carries a fetched register code |
| rcode | output | 8 | Fetched register code |
| done | output | 1 | One-cycle pulse: results valid |

## Verification
Every opcode class is driven with random register contents and random extension bytes, while the acknowledge stall rate is varied. Wrong byte order, a missing sign extension or a wrong offset width all show up as a wrong address. Directed cases push negative displacements, the top byte and halfword lanes of the index register, and the PC-relative wrap. These separate sign extension from zero extension and byte lanes from halfword lanes. Auto-modify runs with all four step codes tell pre-use from post-use updating and show that step code 3 leaves the register alone. Extra start pulses during busy operations, and the count of bytes consumed per operation, show that the handshake and the busy lockout hold.

// File: rtl/eam_pkg.sv
package eam_pkg;

    localparam int EA_W   = 32;
    localparam int RIDX_W = 6;
    localparam int CYC_W  = 4;
    localparam int NBUF   = 3;

    localparam logic [CYC_W-1:0] COST_DISP8  = 4'd2;
    localparam logic [CYC_W-1:0] COST_ABS16  = 4'd2;
    localparam logic [CYC_W-1:0] COST_ABS24  = 4'd3;
    localparam logic [CYC_W-1:0] COST_XLONG  = 4'd8;
    localparam logic [CYC_W-1:0] COST_XSHORT = 4'd5;
    localparam logic [CYC_W-1:0] COST_STEP   = 4'd3;
    localparam logic [CYC_W-1:0] COST_RCODE  = 4'd1;

    typedef enum logic [2:0] {
        K_NONE, K_REGIND, K_REGDISP, K_ABS, K_EXT, K_PREDEC, K_POSTINC, K_RCODE
    } ea_kind_e;

    typedef enum logic [2:0] {
        X_REGREG8, X_REGREG16, X_PCREL, X_REGDISP16, X_REG
    } ext_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CALC, S_INDEX, S_DONE
    } dec_state_e;

    typedef struct packed {
        ea_kind_e         kind;
        logic [1:0]       nbytes;
        logic [2:0]       gsel;
        logic [CYC_W-1:0] cost;
    } op_class_t;

    typedef struct packed {
        ext_kind_e        kind;
        logic [1:0]       nbytes;
        logic [CYC_W-1:0] cost;
    } ext_class_t;

    function automatic logic [EA_W-1:0] sx8(input logic [7:0] v);
        return {{(EA_W-8){v[7]}}, v};
    endfunction

    function automatic logic [EA_W-1:0] sx16(input logic [15:0] v);
        return {{(EA_W-16){v[15]}}, v};
    endfunction

    function automatic logic [EA_W-1:0] step_amount(input logic [1:0] code);
        logic [EA_W-1:0] s;
        case (code)
            2'd0:    s = EA_W'(1);
            2'd1:    s = EA_W'(2);
            2'd2:    s = EA_W'(4);
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/eam_opcode_class.sv
module eam_opcode_class
    import eam_pkg::*;
(
    input  logic [7:0] opcode,
    output op_class_t  cls
);
    always_comb begin
        cls.kind   = K_NONE;
        cls.nbytes = 2'd0;
        cls.gsel   = opcode[2:0];
        cls.cost   = '0;
        if (opcode[7:6] == 2'b10) begin
            if (opcode[3]) begin
                cls.kind   = K_REGDISP;
                cls.nbytes = 2'd1;
                cls.cost   = COST_DISP8;
            end else begin
                cls.kind   = K_REGIND;
            end
        end else if (opcode[7:6] == 2'b11) begin
            case (opcode[3:0])
                4'h0: begin
                    cls.kind = K_ABS; cls.nbytes = 2'd1; cls.cost = COST_ABS16;
                end
                4'h1: begin
                    cls.kind = K_ABS; cls.nbytes = 2'd2; cls.cost = COST_ABS16;
                end
                4'h2: begin
                    cls.kind = K_ABS; cls.nbytes = 2'd3; cls.cost = COST_ABS24;
                end
                4'h3: begin
                    cls.kind = K_EXT; cls.nbytes = 2'd1; cls.cost = COST_XSHORT;
                end
                4'h4: begin
                    cls.kind = K_PREDEC; cls.nbytes = 2'd1; cls.cost = COST_STEP;
                end
                4'h5: begin
                    cls.kind = K_POSTINC; cls.nbytes = 2'd1; cls.cost = COST_STEP;
                end
                4'h7: begin
                    if (opcode != 8'hF7) begin
                        cls.kind = K_RCODE; cls.nbytes = 2'd1; cls.cost = COST_RCODE;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eam_ext_class.sv
module eam_ext_class
    import eam_pkg::*;
(
    input  logic [7:0] mode_byte,
    output ext_class_t xcls
);
    always_comb begin
        xcls.kind   = X_REG;
        xcls.nbytes = 2'd1;
        xcls.cost   = COST_XSHORT;
        if (mode_byte == 8'h03) begin
            xcls.kind = X_REGREG8;  xcls.nbytes = 2'd3; xcls.cost = COST_XLONG;
        end else if (mode_byte == 8'h07) begin
            xcls.kind = X_REGREG16; xcls.nbytes = 2'd3; xcls.cost = COST_XLONG;
        end else if (mode_byte == 8'h13) begin
            xcls.kind = X_PCREL;    xcls.nbytes = 2'd3; xcls.cost = COST_XLONG;
        end else if (mode_byte[1:0] == 2'b01) begin
            xcls.kind = X_REGDISP16; xcls.nbytes = 2'd3;
        end
    end
endmodule

// File: rtl/eam_lane_pick.sv
module eam_lane_pick
    import eam_pkg::*;
(
    input  logic [EA_W-1:0] word,
    input  logic [1:0]      code,
    input  logic            wide,
    output logic [EA_W-1:0] value
);
    logic [7:0]  lane8;
    logic [15:0] lane16;

    always_comb begin
        case (code)
            2'd0:    lane8 = word[7:0];
            2'd1:    lane8 = word[15:8];
            2'd2:    lane8 = word[23:16];
            default: lane8 = word[31:24];
        endcase
        lane16 = code[1] ? word[31:16] : word[15:0];
        value  = wide ? sx16(lane16) : sx8(lane8);
    end
endmodule

// File: rtl/eam_decoder.sv
module eam_decoder
    import eam_pkg::*;
#(
    parameter int GPR_BASE = 56
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [EA_W-1:0]   pc_base,
    output logic              fetch_req,
    input  logic              fetch_ack,
    input  logic [7:0]        fetch_byte,
    output logic [RIDX_W-1:0] rf_rd_idx,
    input  logic [EA_W-1:0]   rf_rd_data,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_wr_idx,
    output logic [EA_W-1:0]   rf_wr_data,
    output logic [EA_W-1:0]   ea,
    output logic [CYC_W-1:0]  extra_cyc,
    output logic              rcode_valid,
    output logic [7:0]        rcode,
    output logic              done
);
    localparam logic [RIDX_W-1:0] GPR_IDX0   = RIDX_W'(GPR_BASE);
    localparam int                PCREL_SKIP = NBUF;

    dec_state_e       st_q;
    ea_kind_e         kind_q;
    logic [2:0]       gsel_q;
    logic [CYC_W-1:0] cost_q;
    logic [1:0]       need_q;
    logic [1:0]       cnt_q;
    logic [1:0]       need_now;
    ext_kind_e        xkind_q;
    logic [CYC_W-1:0] xcost_q;
    logic [EA_W-1:0]  pc_q;
    logic [EA_W-1:0]  base_q;
    logic [7:0]       buf_q [NBUF];

    op_class_t        ocls;
    ext_class_t       xcls;
    logic             accept;
    logic             regreg;
    logic [EA_W-1:0]  lane_val;
    logic [EA_W-1:0]  step;
    logic [EA_W-1:0]  abs_val;

    eam_opcode_class u_ocls (.opcode(opcode), .cls(ocls));
    eam_ext_class    u_xcls (.mode_byte(fetch_byte), .xcls(xcls));
    eam_lane_pick    u_lane (
        .word (rf_rd_data),
        .code (buf_q[2][1:0]),
        .wide (xkind_q == X_REGREG16),
        .value(lane_val)
    );

    assign fetch_req = (st_q == S_FETCH);
    assign accept    = fetch_req && fetch_ack;
    assign done      = (st_q == S_DONE);
    assign need_now  = (kind_q == K_EXT && cnt_q == 2'd0) ? xcls.nbytes : need_q;
    assign regreg    = (xkind_q == X_REGREG8) || (xkind_q == X_REGREG16);
    assign step      = step_amount(buf_q[0][1:0]);

    // extension byte capture, one lane per stream position
    for (genvar gi = 0; gi < NBUF; gi++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst)
                buf_q[gi] <= '0;
            else if (accept && cnt_q == 2'(gi))
                buf_q[gi] <= fetch_byte;
        end
    end

    always_comb begin
        case (need_q)
            2'd1:    abs_val = {{(EA_W-8){1'b0}},  buf_q[0]};
            2'd2:    abs_val = {{(EA_W-16){1'b0}}, buf_q[1], buf_q[0]};
            default: abs_val = {{(EA_W-24){1'b0}}, buf_q[2], buf_q[1], buf_q[0]};
        endcase
    end

    always_comb begin
        rf_rd_idx = GPR_IDX0 + RIDX_W'(gsel_q);
        if (st_q == S_INDEX)
            rf_rd_idx = buf_q[2][7:2];
        else if (kind_q == K_EXT && regreg)
            rf_rd_idx = buf_q[1][7:2];
        else if (kind_q == K_EXT || kind_q == K_PREDEC || kind_q == K_POSTINC)
            rf_rd_idx = buf_q[0][7:2];
    end

    assign rf_we      = (st_q == S_CALC) && (kind_q == K_PREDEC || kind_q == K_POSTINC)
                        && (buf_q[0][1:0] != 2'b11);
    assign rf_wr_idx  = buf_q[0][7:2];
    assign rf_wr_data = (kind_q == K_PREDEC) ? rf_rd_data - step : rf_rd_data + step;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_IDLE;
            kind_q      <= K_NONE;
            gsel_q      <= '0;
            cost_q      <= '0;
            need_q      <= '0;
            cnt_q       <= '0;
            xkind_q     <= X_REG;
            xcost_q     <= '0;
            pc_q        <= '0;
            base_q      <= '0;
            ea          <= '0;
            extra_cyc   <= '0;
            rcode_valid <= 1'b0;
            rcode       <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (start) begin
                        kind_q <= ocls.kind;
                        gsel_q <= ocls.gsel;
                        cost_q <= ocls.cost;
                        need_q <= ocls.nbytes;
                        cnt_q  <= '0;
                        pc_q   <= pc_base;
                        st_q   <= (ocls.nbytes == 2'd0) ? S_CALC : S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (accept) begin
                        cnt_q <= cnt_q + 2'd1;
                        if (kind_q == K_EXT && cnt_q == 2'd0) begin
                            need_q  <= xcls.nbytes;
                            xkind_q <= xcls.kind;
                            xcost_q <= xcls.cost;
                        end
                        if (cnt_q + 2'd1 == need_now)
                            st_q <= S_CALC;
                    end
                end
                S_CALC: begin
                    st_q        <= S_DONE;
                    rcode_valid <= 1'b0;
                    extra_cyc   <= cost_q;
                    ea          <= rf_rd_data;
                    case (kind_q)
                        K_REGIND:  ;
                        K_REGDISP: ea <= rf_rd_data + sx8(buf_q[0]);
                        K_ABS:     ea <= abs_val;
                        K_EXT: begin
                            extra_cyc <= xcost_q;
                            case (xkind_q)
                                X_REGREG8, X_REGREG16: begin
                                    base_q <= rf_rd_data;
                                    st_q   <= S_INDEX;
                                end
                                X_PCREL:     ea <= pc_q + EA_W'(PCREL_SKIP)
                                                   + sx16({buf_q[2], buf_q[1]});
                                X_REGDISP16: ea <= rf_rd_data + sx16({buf_q[2], buf_q[1]});
                                default:     ;
                            endcase
                        end
                        K_PREDEC:  ea <= rf_rd_data - step;
                        K_POSTINC: ;
                        K_RCODE: begin
                            ea          <= '0;
                            rcode       <= buf_q[0];
                            rcode_valid <= 1'b1;
                        end
                        default:   ea <= '0;
                    endcase
                end
                S_INDEX: begin
                    ea   <= base_q + lane_val;
                    st_q <= S_DONE;
                end
                S_DONE:  st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    logic start_none;
    logic start_regind;
    assign start_none   = (st_q == S_IDLE) && start && !opcode[7];
    assign start_regind = (st_q == S_IDLE) && start && (opcode[7:6] == 2'b10) && !opcode[3];

    // R14
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_ack) |=> fetch_req);

    // R12
    none_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $past(start_none, 2) |-> (done && extra_cyc == '0 && !rcode_valid));

    // R2
    regind_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
        start_regind |=> !fetch_req);

    // R11
    rcode_cost_chk: assert property (@(posedge clk) disable iff (rst)
        (done && rcode_valid) |-> (extra_cyc == COST_RCODE && ea == '0));

    // R8
    wb_then_done_chk: assert property (@(posedge clk) disable iff (rst) rf_we |=> done);

    // R10
    wb_moves_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_wr_data != rf_rd_data));

endmodule

// File: tb/eam_decoder_test.sv
`timescale 1ns/1ps
module eam_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [31:0] pc_base = 32'h0;
    logic        fetch_req;
    logic        fetch_ack = 1'b0;
    logic [7:0]  fetch_byte = 8'h00;
    logic [5:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic        rf_we;
    logic [5:0]  rf_wr_idx;
    logic [31:0] rf_wr_data;
    logic [31:0] ea;
    logic [3:0]  extra_cyc;
    logic        rcode_valid;
    logic [7:0]  rcode;
    logic        done;

    logic [31:0] regs [64];
    logic [7:0]  stream [4];
    int          ptr = 0;
    bit          acc_pending = 1'b0;
    int          stall_pct = 0;
    bit          wb_p = 1'b0;
    logic [5:0]  wb_i = '0;
    logic [31:0] wb_d = '0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    eam_decoder uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .pc_base(pc_base),
        .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_byte(fetch_byte),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .ea(ea), .extra_cyc(extra_cyc), .rcode_valid(rcode_valid), .rcode(rcode),
        .done(done)
    );

    assign rf_rd_data = regs[rf_rd_idx];

    always @(posedge clk) begin
        wb_p = rf_we;
        wb_i = rf_wr_idx;
        wb_d = rf_wr_data;
    end

    always @(negedge clk) begin
        if (wb_p) begin
            regs[wb_i] = wb_d;
            wb_p = 1'b0;
        end
        if (acc_pending) ptr = ptr + 1;
        if (fetch_req) begin
            fetch_ack  = (($urandom % 100) >= stall_pct);
            fetch_byte = (ptr < 4) ? stream[ptr] : 8'h00;
        end else begin
            fetch_ack = 1'b0;
        end
        acc_pending = fetch_ack;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [7:0] op, input logic [31:0] pcb,
        output logic [31:0] x_ea, output logic [3:0] x_cyc, output logic x_rv,
        output logic [7:0] x_rc, output int x_n, output logic x_chkreg,
        output logic [5:0] x_wi, output logic [31:0] x_wd, output string tag);
        logic [31:0] r, ix, st;
        logic [7:0]  m;
        x_ea = 0; x_cyc = 0; x_rv = 0; x_rc = 0; x_n = 0;
        x_chkreg = 0; x_wi = 0; x_wd = 0; tag = "R12";
        m = stream[0];
        if (op[7:6] == 2'b10) begin
            r = regs[56 + int'(op[2:0])];
            if (op[3]) begin
                tag = "R3"; x_n = 1; x_cyc = 2; x_ea = r + 32'($signed(m));
            end else begin
                tag = "R2"; x_ea = r;
            end
        end else if (op[7:6] == 2'b11) begin
            case (op[3:0])
                4'h0: begin tag = "R4"; x_n = 1; x_cyc = 2; x_ea = {24'h0, m}; end
                4'h1: begin tag = "R4"; x_n = 2; x_cyc = 2; x_ea = {16'h0, stream[1], m}; end
                4'h2: begin tag = "R4"; x_n = 3; x_cyc = 3;
                            x_ea = {8'h0, stream[2], stream[1], m}; end
                4'h3: begin
                    if (m == 8'h03 || m == 8'h07) begin
                        tag = "R5"; x_n = 3; x_cyc = 8;
                        r  = regs[stream[1][7:2]];
                        ix = regs[stream[2][7:2]];
                        if (m == 8'h03)
                            x_ea = r + 32'($signed(ix[8*stream[2][1:0] +: 8]));
                        else
                            x_ea = r + 32'($signed(stream[2][1] ? ix[31:16] : ix[15:0]));
                    end else if (m == 8'h13) begin
                        tag = "R6"; x_n = 3; x_cyc = 8;
                        x_ea = pcb + 32'd3 + 32'($signed({stream[2], stream[1]}));
                    end else begin
                        tag = "R7"; x_cyc = 5; r = regs[m[7:2]];
                        if (m[1:0] == 2'b01) begin
                            x_n = 3; x_ea = r + 32'($signed({stream[2], stream[1]}));
                        end else begin
                            x_n = 1; x_ea = r;
                        end
                    end
                end
                4'h4, 4'h5: begin
                    x_n = 1; x_cyc = 3; r = regs[m[7:2]];
                    case (m[1:0])
                        2'd0: st = 1;
                        2'd1: st = 2;
                        2'd2: st = 4;
                        default: st = 0;
                    endcase
                    x_chkreg = 1; x_wi = m[7:2];
                    tag = (m[1:0] == 2'b11) ? "R10" : (op[0] ? "R9" : "R8");
                    if (op[3:0] == 4'h4) begin
                        x_ea = r - st; x_wd = r - st;
                    end else begin
                        x_ea = r; x_wd = r + st;
                    end
                end
                4'h7: begin
                    if (op != 8'hF7) begin
                        tag = "R11"; x_n = 1; x_cyc = 1; x_rv = 1; x_rc = m;
                    end
                end
                default: ;
            endcase
        end
    endfunction

    task automatic run_one(input logic [7:0] op, input logic [31:0] pcb, input bit poke);
        logic [31:0] x_ea, x_wd;
        logic [3:0]  x_cyc;
        logic        x_rv, x_chkreg;
        logic [7:0]  x_rc;
        logic [5:0]  x_wi;
        int          x_n;
        int          waited;
        string       tag;
        model(op, pcb, x_ea, x_cyc, x_rv, x_rc, x_n, x_chkreg, x_wi, x_wd, tag);
        @(negedge clk);
        ptr = 0; opcode = op; pc_base = pcb; start = 1'b1;
        @(negedge clk);
        start = poke;
        if (poke) begin
            opcode  = 8'h00;
            pc_base = ~pcb;
        end
        waited = 1;
        @(negedge clk);
        start = 1'b0;
        waited = 2;
        while (!done && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            check(tag, "done timeout", 32'd0, 32'd1);
            return;
        end
        check(tag, "ea", ea, x_ea);
        check(tag, "extra_cyc", 32'(extra_cyc), 32'(x_cyc));
        check(tag, "rcode_valid", 32'(rcode_valid), 32'(x_rv));
        if (x_rv) check(tag, "rcode", 32'(rcode), 32'(x_rc));
        if (tag == "R12") check("R12", "latency", 32'(waited), 32'd2);
        @(negedge clk);
        check("R14", "done pulse width", 32'(done), 32'd0);
        check("R13", "bytes consumed", 32'(ptr), 32'(x_n));
        if (x_chkreg) check(tag, "register after", regs[x_wi], x_wd);
    endtask

    task automatic set_stream(input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input logic [7:0] b3);
        stream[0] = b0; stream[1] = b1; stream[2] = b2; stream[3] = b3;
    endtask

    task automatic fill_regs();
        for (int i = 0; i < 64; i++) regs[i] = $urandom;
    endtask

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        fill_regs();
        set_stream(8'h00, 8'h00, 8'h00, 8'h00);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "done", 32'(done), 32'd0);
        check("R1", "fetch_req", 32'(fetch_req), 32'd0);
        check("R1", "rf_we", 32'(rf_we), 32'd0);
        check("R1", "rcode_valid", 32'(rcode_valid), 32'd0);
        check("R1", "ea", ea, 32'd0);

        // directed corner cases
        regs[59] = 32'h1234_5678;
        run_one(8'h83, 32'h100, 0);                              // R2
        set_stream(8'h80, 0, 0, 0);
        run_one(8'h8F, 32'h100, 0);                              // R3 negative offset
        stall_pct = 80;
        set_stream(8'hFE, 8'h11, 8'h22, 8'h33);
        run_one(8'hC0, 32'h0, 0);                                // R4 abs8
        run_one(8'hD1, 32'h0, 0);                                // R4 abs16
        run_one(8'hE2, 32'h0, 0);                                // R4 abs24
        stall_pct = 0;
        regs[10] = 32'h8000_0000; regs[20] = 32'h80FF_7F01;
        set_stream(8'h03, 8'h28, 8'h53, 8'h00);
        run_one(8'hC3, 32'h0, 0);                                // R5 top byte lane
        set_stream(8'h07, 8'h28, 8'h52, 8'h00);
        run_one(8'hD3, 32'h0, 0);                                // R5 high halfword
        set_stream(8'h13, 8'h00, 8'h80, 8'h00);
        run_one(8'hE3, 32'hFFFF_FFFE, 0);                        // R6 wrap
        set_stream(8'h21, 8'hFF, 8'hFF, 8'h00);
        run_one(8'hC3, 32'h0, 0);                                // R7 disp16
        set_stream(8'h0B, 8'h55, 8'h66, 8'h00);
        run_one(8'hC3, 32'h0, 0);                                // R7 plain, one byte
        regs[5] = 32'h0000_0002;
        for (int c = 0; c < 4; c++) begin
            set_stream(8'((5 << 2) | c), 0, 0, 0);
            run_one(8'hC4, 32'h0, 0);                            // R8 / R10
            set_stream(8'((5 << 2) | c), 0, 0, 0);
            run_one(8'hD5, 32'h0, 0);                            // R9 / R10
        end
        set_stream(8'hE5, 0, 0, 0);
        run_one(8'hC7, 32'h0, 0);                                // R11
        run_one(8'hF7, 32'h0, 0);                                // R12
        run_one(8'h40, 32'h0, 0);                                // R12
        run_one(8'hC6, 32'h0, 0);                                // R12
        run_one(8'hCA, 32'h0, 0);                                // R12
        stall_pct = 50;
        set_stream(8'h13, 8'h10, 8'h00, 8'h00);
        run_one(8'hE3, 32'h4000, 1);                             // R14 start while busy
        run_one(8'h85, 32'h4000, 1);                             // R14

        // constrained random
        for (int t = 0; t < 400; t++) begin
            logic [7:0] op;
            int         sel;
            if (t % 16 == 0) fill_regs();
            stall_pct = $urandom % 61;
            op = 8'($urandom);
            if (!op[7] && ($urandom % 4 != 0)) op[7] = 1'b1;
            set_stream(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            if (op[7:6] == 2'b11 && op[3:0] == 4'h3) begin
                sel = $urandom % 4;
                if (sel == 0) stream[0] = 8'h03;
                else if (sel == 1) stream[0] = 8'h07;
                else if (sel == 2) stream[0] = 8'h13;
            end
            run_one(op, $urandom, ($urandom % 8) == 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule